// File: doc/BRIEF.md
# Vector Floating-Point FMA Operand Steering

This block sits in front of a row of identical fused multiply-add lanes. For each vector element group it takes an opcode, a flag that selects the vector-vector or the vector-scalar form, the dynamic rounding mode and the source register values. From these it produces, per lane, the three raw FMA inputs `a`, `b` and `c` and two sign controls. The lane then computes `(-1)^np * a*b + (-1)^na * c` with a single rounding.

Plain add, subtract and reverse subtract are mapped onto the fused datapath with a multiply by exact 1.0. Multiply is mapped with a signed zero addend, and that sign is chosen so that zero results keep their IEEE sign. The two FMA families differ only in which register is the overwritten one. When that register is the addend, the product is `operand*vs2` and the addend is `vd`. When it is a multiplicand, the product is `operand*vd` and the addend is `vs2`.

In the scalar form, the floating-point scalar is checked for NaN-boxing and then broadcast to every lane. The outputs are registered, and an element-group tag travels with them.

Top module: `vfp_operand_steer`

## Requirements
- R1: A bundle accepted with `in_valid` high appears on the outputs one clock later with `out_valid` high and `out_group` equal to the accepted tag. A cycle without `in_valid` gives `out_valid` low in the next cycle.
- R2: Add (op 0) gives a=vs2[i], b=1.0 (0x3C00 at SEW=16), c=operand, with both signs clear. Subtract (op 1) is the same with the addend negated. Here operand is vs1[i] in the vector form and the scalar in the scalar form.
- R3: Reverse subtract (op 2) in the scalar form gives a=scalar, b=1.0, c=vs2[i], with the addend negated. In the vector form it raises `out_illegal`, and a, b, c and both signs are all zero.
- R4: Multiply (op 3) gives a=vs2[i], b=operand and c=-0 (0x8000). When the rounding mode is round-down (3'b010), c=+0 (0x0000) instead. Both signs are clear.
- R5: The addend-overwriting family (ops 4..7) gives a=operand, b=vs2[i] and c=vd[i], all bit-exact.
- R6: The multiplicand-overwriting family (ops 8..11) gives a=operand, b=vd[i] and c=vs2[i], all bit-exact.
- R7: For ops 4..11, the low two opcode bits select the signs as pairs (negate product, negate addend): 00 gives (0,0), 01 gives (1,1), 10 gives (0,1), 11 gives (1,0). Every lane carries the same sign pair.
- R8: In the scalar form, every lane receives the same scalar value.
- R9: If the upper FLEN-SEW bits of the 32-bit scalar are not all ones, the scalar is replaced by the canonical quiet NaN (0x7E00 at SEW=16).
- R10: Opcodes 12..15 raise `out_illegal` with a, b, c and both signs all zero.
- R11: After reset, `out_valid` and `out_illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bundle valid |
| in_op | input | 4 | Operation code |
| in_scalar_form | input | 1 | 1 = vector-scalar form, 0 = vector-vector |
| in_rm | input | 3 | Dynamic rounding mode |
| in_group | input | GW | Element-group tag |
| in_vs1 | input | LANES*SEW | First vector source, lane 0 in the low bits |
| in_vs2 | input | LANES*SEW | Second vector source |
| in_vd | input | LANES*SEW | Destination register's old value |
| in_fscalar | input | FLEN | Floating-point scalar register |
| out_valid | output | 1 | Output bundle valid |
| out_illegal | output | 1 | Encoding not allowed |
| out_group | output | GW | Element-group tag |
| out_a | output | LANES*SEW | Multiplicand A per lane |
| out_b | output | LANES*SEW | Multiplicand B per lane |
| out_c | output | LANES*SEW | Addend per lane |
| out_neg_prod | output | LANES | Negate product, per lane |
| out_neg_add | output | LANES | Negate addend, per lane |

## Verification
The bench builds the block with LANES=4, SEW=16, FLEN=32 and GW=3. This makes the NaN-boxing check live: the upper 16 scalar bits are a real field. With four lanes, a broadcast or a per-lane role swap shows up as distinct lane values. The 16-bit format fixes the constants 1.0, the signed zeros and the quiet NaN at values the bench can state by hand. It also lets each opcode's operand roles be told apart by picking distinct lane patterns for vs1, vs2 and vd.

// File: rtl/vfp_steer_pkg.sv
package vfp_steer_pkg;

    localparam logic [3:0] OP_ADD   = 4'd0;
    localparam logic [3:0] OP_SUB   = 4'd1;
    localparam logic [3:0] OP_RSUB  = 4'd2;
    localparam logic [3:0] OP_MUL   = 4'd3;
    localparam logic [3:0] OP_MACC  = 4'd4;
    localparam logic [3:0] OP_NMACC = 4'd5;
    localparam logic [3:0] OP_MSAC  = 4'd6;
    localparam logic [3:0] OP_NMSAC = 4'd7;
    localparam logic [3:0] OP_MADD  = 4'd8;
    localparam logic [3:0] OP_NMADD = 4'd9;
    localparam logic [3:0] OP_MSUB  = 4'd10;
    localparam logic [3:0] OP_NMSUB = 4'd11;

    localparam logic [2:0] RM_DOWN  = 3'b010;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_VS1,
        SEL_VS2,
        SEL_VD,
        SEL_SCAL,
        SEL_ONE,
        SEL_ZERO
    } src_sel_e;

    typedef struct packed {
        src_sel_e sel_a;
        src_sel_e sel_b;
        src_sel_e sel_c;
        logic     neg_prod;
        logic     neg_add;
        logic     illegal;
    } role_t;

    // exponent field width of a binary format of the given width
    function automatic int fp_exp_w(input int sew);
        if (sew <= 16)      return 5;
        else if (sew <= 32) return 8;
        else                return 11;
    endfunction

    // encoding of +1.0
    function automatic logic [63:0] fp_one(input int sew);
        logic [63:0] bias;
        bias = (64'd1 << (fp_exp_w(sew) - 1)) - 64'd1;
        return bias << (sew - 1 - fp_exp_w(sew));
    endfunction

    // canonical quiet NaN: sign clear, exponent all ones, top fraction bit set
    function automatic logic [63:0] fp_qnan(input int sew);
        logic [63:0] expo;
        expo = (64'd1 << fp_exp_w(sew)) - 64'd1;
        return (expo << (sew - 1 - fp_exp_w(sew))) | (64'd1 << (sew - 2 - fp_exp_w(sew)));
    endfunction

endpackage

// File: rtl/vfp_scalar_unbox.sv
module vfp_scalar_unbox #(
    parameter int SEW  = 16,
    parameter int FLEN = 32
) (
    input  logic [FLEN-1:0] scalar_i,
    output logic [SEW-1:0]  elem_o
);
    import vfp_steer_pkg::*;

    localparam logic [SEW-1:0] QNAN = SEW'(fp_qnan(SEW));

    generate
        if (FLEN > SEW) begin : g_boxed
            localparam int PAD = FLEN - SEW;
            logic boxed;
            always_comb begin
                boxed  = &scalar_i[FLEN-1:SEW];
                elem_o = boxed ? scalar_i[SEW-1:0] : QNAN;
            end
        end else begin : g_plain
            logic [FLEN-1:0] unused_hi;
            always_comb begin
                elem_o    = scalar_i[SEW-1:0];
                unused_hi = scalar_i;
            end
        end
    endgenerate

endmodule

// File: rtl/vfp_role_decode.sv
module vfp_role_decode (
    input  logic [3:0]           op_i,
    input  logic                 scalar_form_i,
    output vfp_steer_pkg::role_t role_o
);
    import vfp_steer_pkg::*;

    src_sel_e operand;
    logic     fma_np;
    logic     fma_na;

    always_comb begin
        operand = scalar_form_i ? SEL_SCAL : SEL_VS1;
        // sign pattern order: +/+, -/-, +/-, -/+
        fma_np  = op_i[0];
        fma_na  = op_i[0] ^ op_i[1];

        role_o  = '{sel_a: SEL_NONE, sel_b: SEL_NONE, sel_c: SEL_NONE,
                    neg_prod: 1'b0, neg_add: 1'b0, illegal: 1'b0};

        unique case (op_i)
            OP_ADD, OP_SUB: begin
                role_o.sel_a   = SEL_VS2;
                role_o.sel_b   = SEL_ONE;
                role_o.sel_c   = operand;
                role_o.neg_add = (op_i == OP_SUB);
            end
            OP_RSUB: begin
                if (scalar_form_i) begin
                    role_o.sel_a   = SEL_SCAL;
                    role_o.sel_b   = SEL_ONE;
                    role_o.sel_c   = SEL_VS2;
                    role_o.neg_add = 1'b1;
                end else begin
                    role_o.illegal = 1'b1;
                end
            end
            OP_MUL: begin
                role_o.sel_a = SEL_VS2;
                role_o.sel_b = operand;
                role_o.sel_c = SEL_ZERO;
            end
            OP_MACC, OP_NMACC, OP_MSAC, OP_NMSAC: begin
                role_o.sel_a    = operand;
                role_o.sel_b    = SEL_VS2;
                role_o.sel_c    = SEL_VD;
                role_o.neg_prod = fma_np;
                role_o.neg_add  = fma_na;
            end
            OP_MADD, OP_NMADD, OP_MSUB, OP_NMSUB: begin
                role_o.sel_a    = operand;
                role_o.sel_b    = SEL_VD;
                role_o.sel_c    = SEL_VS2;
                role_o.neg_prod = fma_np;
                role_o.neg_add  = fma_na;
            end
            default: begin
                role_o.illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/vfp_lane_mux.sv
module vfp_lane_mux #(
    parameter int SEW = 16
) (
    input  vfp_steer_pkg::role_t role_i,
    input  logic [SEW-1:0]       vs1_i,
    input  logic [SEW-1:0]       vs2_i,
    input  logic [SEW-1:0]       vd_i,
    input  logic [SEW-1:0]       scal_i,
    input  logic [SEW-1:0]       one_i,
    input  logic [SEW-1:0]       zero_i,
    output logic [SEW-1:0]       a_o,
    output logic [SEW-1:0]       b_o,
    output logic [SEW-1:0]       c_o
);
    import vfp_steer_pkg::*;

    function automatic logic [SEW-1:0] pick(input src_sel_e sel,
                                            input logic [SEW-1:0] v1,
                                            input logic [SEW-1:0] v2,
                                            input logic [SEW-1:0] vd,
                                            input logic [SEW-1:0] sc,
                                            input logic [SEW-1:0] one,
                                            input logic [SEW-1:0] zero);
        logic [SEW-1:0] r;
        unique case (sel)
            SEL_VS1:  r = v1;
            SEL_VS2:  r = v2;
            SEL_VD:   r = vd;
            SEL_SCAL: r = sc;
            SEL_ONE:  r = one;
            SEL_ZERO: r = zero;
            default:  r = '0;
        endcase
        return r;
    endfunction

    logic unused_signs;

    always_comb begin
        a_o = pick(role_i.sel_a, vs1_i, vs2_i, vd_i, scal_i, one_i, zero_i);
        b_o = pick(role_i.sel_b, vs1_i, vs2_i, vd_i, scal_i, one_i, zero_i);
        c_o = pick(role_i.sel_c, vs1_i, vs2_i, vd_i, scal_i, one_i, zero_i);
        unused_signs = role_i.neg_prod ^ role_i.neg_add ^ role_i.illegal;
    end

endmodule

// File: rtl/vfp_operand_steer.sv
module vfp_operand_steer #(
    parameter int LANES = 4,
    parameter int SEW   = 16,
    parameter int FLEN  = 32,
    parameter int GW    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [3:0]             in_op,
    input  logic                   in_scalar_form,
    input  logic [2:0]             in_rm,
    input  logic [GW-1:0]          in_group,
    input  logic [LANES*SEW-1:0]   in_vs1,
    input  logic [LANES*SEW-1:0]   in_vs2,
    input  logic [LANES*SEW-1:0]   in_vd,
    input  logic [FLEN-1:0]        in_fscalar,
    output logic                   out_valid,
    output logic                   out_illegal,
    output logic [GW-1:0]          out_group,
    output logic [LANES*SEW-1:0]   out_a,
    output logic [LANES*SEW-1:0]   out_b,
    output logic [LANES*SEW-1:0]   out_c,
    output logic [LANES-1:0]       out_neg_prod,
    output logic [LANES-1:0]       out_neg_add
);
    import vfp_steer_pkg::*;

    localparam int              VW  = LANES * SEW;
    localparam logic [SEW-1:0]  ONE = SEW'(fp_one(SEW));

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [GW-1:0]    grp;
        logic [VW-1:0]    a;
        logic [VW-1:0]    b;
        logic [VW-1:0]    c;
        logic [LANES-1:0] np;
        logic [LANES-1:0] na;
    } bundle_t;

    bundle_t        st_d, st_q;
    role_t          role;
    logic [SEW-1:0] scal_elem;
    logic [SEW-1:0] zero_elem;
    logic [VW-1:0]  lane_a, lane_b, lane_c;

    vfp_scalar_unbox #(.SEW(SEW), .FLEN(FLEN)) i_unbox (
        .scalar_i (in_fscalar),
        .elem_o   (scal_elem)
    );

    vfp_role_decode i_decode (
        .op_i          (in_op),
        .scalar_form_i (in_scalar_form),
        .role_o        (role)
    );

    // signed zero addend for multiply: -0 keeps the product's sign except
    // when rounding down, where +0 does
    always_comb begin
        zero_elem = {(in_rm != RM_DOWN), {(SEW-1){1'b0}}};
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            vfp_lane_mux #(.SEW(SEW)) i_mux (
                .role_i (role),
                .vs1_i  (in_vs1[l*SEW +: SEW]),
                .vs2_i  (in_vs2[l*SEW +: SEW]),
                .vd_i   (in_vd[l*SEW +: SEW]),
                .scal_i (scal_elem),
                .one_i  (ONE),
                .zero_i (zero_elem),
                .a_o    (lane_a[l*SEW +: SEW]),
                .b_o    (lane_b[l*SEW +: SEW]),
                .c_o    (lane_c[l*SEW +: SEW])
            );
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.illegal = role.illegal;
            st_d.grp     = in_group;
            st_d.a       = lane_a;
            st_d.b       = lane_b;
            st_d.c       = lane_c;
            st_d.np      = {LANES{role.neg_prod}};
            st_d.na      = {LANES{role.neg_add}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign out_illegal  = st_q.illegal;
    assign out_group    = st_q.grp;
    assign out_a        = st_q.a;
    assign out_b        = st_q.b;
    assign out_c        = st_q.c;
    assign out_neg_prod = st_q.np;
    assign out_neg_add  = st_q.na;

endmodule

// File: rtl/vfp_operand_steer_chk.sv
module vfp_operand_steer_chk #(
    parameter int LANES = 4,
    parameter int SEW   = 16,
    parameter int FLEN  = 32,
    parameter int GW    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [3:0]           in_op,
    input logic                 in_scalar_form,
    input logic [GW-1:0]        in_group,
    input logic [LANES*SEW-1:0] in_vd,
    input logic [FLEN-1:0]      in_fscalar,
    input logic                 out_valid,
    input logic                 out_illegal,
    input logic [GW-1:0]        out_group,
    input logic [LANES*SEW-1:0] out_a,
    input logic [LANES*SEW-1:0] out_c,
    input logic [LANES-1:0]     out_neg_prod,
    input logic [LANES-1:0]     out_neg_add
);
    import vfp_steer_pkg::*;

    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r1_group_carried: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_group == $past(in_group));

    a_r3_rsub_vv_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_RSUB && !in_scalar_form)
        |=> (out_illegal && out_a == '0 && out_c == '0 && out_neg_add == '0));

    a_r5_addend_is_vd: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_MACC) |=> out_c == $past(in_vd));

    a_r7_uniform_signs: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($countones(out_neg_prod) == 0 || $countones(out_neg_prod) == LANES) &&
                       ($countones(out_neg_add)  == 0 || $countones(out_neg_add)  == LANES)));

    a_r8_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_scalar_form && in_op == OP_MACC)
        |=> out_a == {LANES{out_a[SEW-1:0]}});

    generate
        if (FLEN > SEW) begin : g_box_chk
            a_r9_unboxed_qnan: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_scalar_form && in_op == OP_MACC && !(&in_fscalar[FLEN-1:SEW]))
                |=> out_a == {LANES{SEW'(fp_qnan(SEW))}});
        end
    endgenerate

endmodule

bind vfp_operand_steer vfp_operand_steer_chk #(
    .LANES (LANES),
    .SEW   (SEW),
    .FLEN  (FLEN),
    .GW    (GW)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_op          (in_op),
    .in_scalar_form (in_scalar_form),
    .in_group       (in_group),
    .in_vd          (in_vd),
    .in_fscalar     (in_fscalar),
    .out_valid      (out_valid),
    .out_illegal    (out_illegal),
    .out_group      (out_group),
    .out_a          (out_a),
    .out_c          (out_c),
    .out_neg_prod   (out_neg_prod),
    .out_neg_add    (out_neg_add)
);

// File: tb/test_vfp_operand_steer.sv
module test_vfp_operand_steer;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int SEW   = 16;
    localparam int FLEN  = 32;
    localparam int GW    = 3;
    localparam int VW    = LANES * SEW;

    localparam logic [15:0] ONE   = 16'h3C00;
    localparam logic [15:0] QNAN  = 16'h7E00;
    localparam logic [15:0] NZERO = 16'h8000;

    localparam logic [VW-1:0] VS1 = {16'h4000, 16'h4200, 16'h4400, 16'h4600};
    localparam logic [VW-1:0] VS2 = {16'h3800, 16'hBC00, 16'h5000, 16'h0001};
    localparam logic [VW-1:0] VD  = {16'hC000, 16'h7C00, 16'h0000, 16'h8000};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [3:0]           in_op = '0;
    logic                 in_scalar_form = 1'b0;
    logic [2:0]           in_rm = '0;
    logic [GW-1:0]        in_group = '0;
    logic [VW-1:0]        in_vs1 = '0;
    logic [VW-1:0]        in_vs2 = '0;
    logic [VW-1:0]        in_vd = '0;
    logic [FLEN-1:0]      in_fscalar = '0;
    logic                 out_valid;
    logic                 out_illegal;
    logic [GW-1:0]        out_group;
    logic [VW-1:0]        out_a, out_b, out_c;
    logic [LANES-1:0]     out_neg_prod, out_neg_add;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfp_operand_steer #(.LANES(LANES), .SEW(SEW), .FLEN(FLEN), .GW(GW)) i_vfp_operand_steer (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
        .in_scalar_form (in_scalar_form), .in_rm (in_rm), .in_group (in_group),
        .in_vs1 (in_vs1), .in_vs2 (in_vs2), .in_vd (in_vd), .in_fscalar (in_fscalar),
        .out_valid (out_valid), .out_illegal (out_illegal), .out_group (out_group),
        .out_a (out_a), .out_b (out_b), .out_c (out_c),
        .out_neg_prod (out_neg_prod), .out_neg_add (out_neg_add)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at the falling edge, let one rising edge register, sample at the next falling edge
    task automatic issue(input logic [3:0] op, input logic vf, input logic [2:0] rm,
                         input logic [GW-1:0] grp, input logic [FLEN-1:0] fs);
        in_valid = 1'b1; in_op = op; in_scalar_form = vf; in_rm = rm;
        in_group = grp; in_vs1 = VS1; in_vs2 = VS2; in_vd = VD; in_fscalar = fs;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 valid after reset", 64'(out_valid), 64'd0);
        chk("R11 illegal after reset", 64'(out_illegal), 64'd0);
    endtask

    task automatic t_add_sub();
        issue(4'd0, 1'b0, 3'd0, 3'd5, 32'hFFFF_4500);
        chk("R1 valid", 64'(out_valid), 64'd1);
        chk("R1 group", 64'(out_group), 64'd5);
        chk("R2 add a", out_a, VS2);
        chk("R2 add b", out_b, {4{ONE}});
        chk("R2 add c", out_c, VS1);
        chk("R2 add signs", {out_neg_prod, out_neg_add}, 64'h00);
        issue(4'd1, 1'b1, 3'd0, 3'd6, 32'hFFFF_4500);
        chk("R1 back-to-back group", 64'(out_group), 64'd6);
        chk("R8 sub vf c broadcast", out_c, {4{16'h4500}});
        chk("R2 sub neg_add", 64'(out_neg_add), 64'hF);
        chk("R2 sub neg_prod", 64'(out_neg_prod), 64'h0);
        idle();
        chk("R1 idle drops valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_rsub();
        issue(4'd2, 1'b1, 3'd0, 3'd1, 32'hFFFF_C100);
        chk("R3 rsub a", out_a, {4{16'hC100}});
        chk("R3 rsub b", out_b, {4{ONE}});
        chk("R3 rsub c", out_c, VS2);
        chk("R3 rsub signs", {out_neg_prod, out_neg_add}, 64'h0F);
        chk("R3 rsub legal", 64'(out_illegal), 64'd0);
        issue(4'd2, 1'b0, 3'd0, 3'd2, 32'hFFFF_C100);
        chk("R3 rsub vv illegal", 64'(out_illegal), 64'd1);
        chk("R3 rsub vv zero a", out_a, 64'd0);
        chk("R3 rsub vv zero b", out_b, 64'd0);
        chk("R3 rsub vv zero c", out_c, 64'd0);
        chk("R3 rsub vv zero signs", {out_neg_prod, out_neg_add}, 64'h00);
        idle();
    endtask

    task automatic t_mul();
        issue(4'd3, 1'b0, 3'd0, 3'd3, 32'hFFFF_0000);
        chk("R4 mul a", out_a, VS2);
        chk("R4 mul b", out_b, VS1);
        chk("R4 mul c -0", out_c, {4{NZERO}});
        issue(4'd3, 1'b1, 3'b010, 3'd4, 32'hFFFF_4900);
        chk("R4 mul rdn c +0", out_c, 64'd0);
        chk("R4 mul vf b", out_b, {4{16'h4900}});
        chk("R4 mul signs", {out_neg_prod, out_neg_add}, 64'h00);
        issue(4'd3, 1'b0, 3'b011, 3'd4, 32'hFFFF_0000);
        chk("R4 mul rup c -0", out_c, {4{NZERO}});
        idle();
    endtask

    task automatic t_fma_families();
        logic [7:0] sg [4];
        sg[0] = 8'h00; sg[1] = 8'hFF; sg[2] = 8'h0F; sg[3] = 8'hF0;
        for (int k = 0; k < 4; k++) begin
            issue(4'(4 + k), 1'b0, 3'd0, 3'(k), 32'hFFFF_0000);
            chk("R5 acc a", out_a, VS1);
            chk("R5 acc b", out_b, VS2);
            chk("R5 acc c", out_c, VD);
            chk("R7 acc signs", {out_neg_prod, out_neg_add}, 64'(sg[k]));
        end
        for (int k = 0; k < 4; k++) begin
            issue(4'(8 + k), 1'b1, 3'd0, 3'(k), 32'hFFFF_3555);
            chk("R6 mad a", out_a, {4{16'h3555}});
            chk("R6 mad b", out_b, VD);
            chk("R6 mad c", out_c, VS2);
            chk("R7 mad signs", {out_neg_prod, out_neg_add}, 64'(sg[k]));
        end
        idle();
    endtask

    task automatic t_nanbox();
        issue(4'd4, 1'b1, 3'd0, 3'd7, 32'h0000_4500);
        chk("R9 unboxed zero upper", out_a, {4{QNAN}});
        issue(4'd4, 1'b1, 3'd0, 3'd7, 32'hFFFE_4500);
        chk("R9 unboxed one bit", out_a, {4{QNAN}});
        issue(4'd4, 1'b1, 3'd0, 3'd7, 32'hFFFF_4500);
        chk("R9 boxed passes", out_a, {4{16'h4500}});
        idle();
    endtask

    task automatic t_bad_op();
        for (int k = 12; k < 16; k++) begin
            issue(4'(k), 1'b1, 3'd0, 3'd0, 32'hFFFF_4500);
            chk("R10 illegal op", 64'(out_illegal), 64'd1);
            chk("R10 zero a", out_a, 64'd0);
            chk("R10 zero c", out_c, 64'd0);
            chk("R10 zero signs", {out_neg_prod, out_neg_add}, 64'h00);
        end
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_add_sub();
        t_rsub();
        t_mul();
        t_fma_families();
        t_nanbox();
        t_bad_op();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule